// File: doc/BRIEF.md
# Serial Bus Collision and Arbitration Monitor

This block sits next to a serial transmitter that drives a shared open-drain data line. At each sampling event it compares the level the transmitter drives with the level it reads back from the wire. If the transmitter has released the line high but the wire reads low, another device is driving the bus. The block then emits a collision pulse, updates a sticky arbitration-lost flag and can ask the transmitter to drop its enable. Software selects the sampling event: a rising edge of the serial clock or a timer underflow pulse. Software also selects whether the arbitration flag follows each bit or is committed once per byte at a byte-boundary strobe.

In the two-wire bus mode the block also follows START and STOP conditions on the clock and data lines to maintain a bus-busy flag. Separately, it produces the transmitter's start pulse. That pulse comes either as soon as transmit is enabled, or on the first falling edge of the receive line after transmit is enabled. All wire inputs pass through a parameterised synchroniser before any edge or level decision is made. The driven level passes through an equal-length delay so that it stays aligned with the wire level it is compared against.

Top module: `sbus_arb_monitor`

## Requirements
- R1: While reset is asserted and right after reset is released, bus_busy, arb_lost, coll_pulse, tx_en_clr and tx_start are all 0.
- R2: With cfg_i2c_mode=1, a START condition sets bus_busy and a STOP condition clears it. A START is the data line going 1 to 0 while the clock line is 1, and a STOP is the data line going 0 to 1 while the clock line is 1. bus_busy changes SYNC_STAGES+1 cycles after the input edge is first sampled.
- R3: With cfg_i2c_mode=0, bus_busy stays 0 and START/STOP conditions are ignored.
- R4: At a sampling event, coll_pulse is high for exactly one cycle when sda_drv=1 and the synchronised sda_in=0. When the driven level is 0, or the wire matches the driven level, no pulse is produced.
- R5: With cfg_smp_timer=0, the sampling event is a synchronised rising edge of scl_in. The collision pulse appears SYNC_STAGES+1 cycles after the clock edge is first sampled, and tmr_uflow has no effect.
- R6: With cfg_smp_timer=1, the sampling event is a tmr_uflow pulse, and the collision pulse appears one cycle after it. Rising edges of scl_in have no effect.
- R7: With cfg_byte_upd=0, arb_lost becomes 1 in the same cycle as coll_pulse.
- R8: With cfg_byte_upd=1, a collision is held pending and arb_lost becomes 1 one cycle after the next byte_end strobe. It stays 0 before that strobe. A byte_end strobe with no pending collision leaves arb_lost at 0.
- R9: arb_lost is sticky. A one-cycle arb_clr pulse clears it, but a collision that sets it in the same cycle takes priority over the clear.
- R10: With cfg_auto_clr=1, tx_en_clr pulses in the same cycle as every coll_pulse. With cfg_auto_clr=0, tx_en_clr stays 0.
- R11: With cfg_start_on_fall=0, tx_start pulses for one cycle, one cycle after tx_en rises.
- R12: With cfg_start_on_fall=1, a rise of tx_en arms the trigger. tx_start then pulses once, SYNC_STAGES+1 cycles after the first falling edge of rxd_in is sampled. Later falling edges are ignored until tx_en falls and rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_i2c_mode | input | 1 | 1 selects two-wire bus mode with START/STOP tracking |
| cfg_smp_timer | input | 1 | Collision sampling event: 0 clock rise, 1 timer underflow |
| cfg_byte_upd | input | 1 | Arbitration flag update: 0 per bit, 1 per byte |
| cfg_auto_clr | input | 1 | 1 requests a transmit-enable clear on collision |
| cfg_start_on_fall | input | 1 | 1 makes transmission wait for a receive-line fall |
| scl_in | input | 1 | Serial clock line level (asynchronous) |
| sda_in | input | 1 | Data line level read back (asynchronous) |
| sda_drv | input | 1 | Level the transmitter drives, 1 = released |
| rxd_in | input | 1 | Receive data line (asynchronous) |
| tmr_uflow | input | 1 | Timer underflow pulse, one cycle |
| byte_end | input | 1 | Byte-boundary strobe, one cycle |
| tx_en | input | 1 | Transmitter enable level |
| arb_clr | input | 1 | Software clear of the arbitration-lost flag |
| bus_busy | output | 1 | Bus-busy flag |
| arb_lost | output | 1 | Sticky arbitration-lost flag |
| coll_pulse | output | 1 | One-cycle collision detect pulse |
| tx_en_clr | output | 1 | One-cycle request to clear transmit enable |
| tx_start | output | 1 | One-cycle transmit start pulse |

## Verification
The bench builds the block with SYNC_STAGES=3 rather than the default of 2. This exercises the general synchroniser depth and shows that the driven-level delay stays aligned with the wire path at a non-default length. Every expected pulse cycle and flag latency is derived from that parameter, so an off-by-one stage anywhere in the line path moves a pulse away from the predicted cycle. Both sampling sources and both flag update modes are exercised, along with the priority of a collision over a clear in the same cycle.

// File: rtl/sbam_pkg.sv
package sbam_pkg;

    localparam int LINE_W = 4;

    typedef struct packed {
        logic scl;
        logic sda;
        logic drv;
        logic rxd;
    } line_t;

    typedef enum logic {
        SMP_CLK_RISE = 1'b0,
        SMP_TIMER    = 1'b1
    } smp_src_e;

    typedef struct packed {
        logic     i2c_mode;
        smp_src_e smp_src;
        logic     byte_upd;
        logic     auto_clr;
        logic     start_on_fall;
    } cfg_t;

    typedef struct packed {
        logic scl_rise;
        logic start_cond;
        logic stop_cond;
        logic rxd_fall;
    } evt_t;

    function automatic logic rose(input logic now, input logic prev);
        return now & ~prev;
    endfunction

    function automatic logic fell(input logic now, input logic prev);
        return ~now & prev;
    endfunction

endpackage

// File: rtl/sbam_sync.sv
module sbam_sync #(
    parameter int                STAGES  = 2,
    parameter int                WIDTH   = 4,
    parameter logic [WIDTH-1:0]  RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) begin
                chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sbam_cond_det.sv
module sbam_cond_det
    import sbam_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic i2c_mode,
    input  evt_t evt,
    output logic bus_busy
);
    logic busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
        end else if (!i2c_mode) begin
            busy_q <= 1'b0;
        end else if (evt.start_cond) begin
            busy_q <= 1'b1;
        end else if (evt.stop_cond) begin
            busy_q <= 1'b0;
        end
    end

    assign bus_busy = busy_q;

    // R3
    busy_needs_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !i2c_mode |=> !bus_busy);

    // R2
    busy_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bus_busy) |-> $past(evt.start_cond));
endmodule

// File: rtl/sbam_coll.sv
module sbam_coll
    import sbam_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  smp_src_e smp_src,
    input  logic     byte_upd,
    input  logic     auto_clr,
    input  logic     scl_rise,
    input  logic     tmr_uflow,
    input  logic     drv_lvl,
    input  logic     wire_lvl,
    input  logic     byte_end,
    input  logic     arb_clr,
    output logic     coll_pulse,
    output logic     tx_en_clr,
    output logic     arb_lost
);
    logic smp_evt;
    logic hit;
    logic arb_set;
    logic pend_q;
    logic coll_q;
    logic clr_q;
    logic arb_q;

    always_comb begin
        unique case (smp_src)
            SMP_TIMER:    smp_evt = tmr_uflow;
            default:      smp_evt = scl_rise;
        endcase
        hit     = smp_evt & drv_lvl & ~wire_lvl;
        arb_set = byte_upd ? (byte_end & (pend_q | hit)) : hit;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coll_q <= 1'b0;
            clr_q  <= 1'b0;
            pend_q <= 1'b0;
            arb_q  <= 1'b0;
        end else begin
            coll_q <= hit;
            clr_q  <= hit & auto_clr;
            if (!byte_upd || byte_end) begin
                pend_q <= 1'b0;
            end else if (hit) begin
                pend_q <= 1'b1;
            end
            if (arb_set) begin
                arb_q <= 1'b1;
            end else if (arb_clr) begin
                arb_q <= 1'b0;
            end
        end
    end

    assign coll_pulse = coll_q;
    assign tx_en_clr  = clr_q;
    assign arb_lost   = arb_q;

    // R10
    clr_with_coll_chk: assert property (@(posedge clk) disable iff (rst)
        tx_en_clr |-> coll_pulse);

    // R7
    bit_mode_flag_chk: assert property (@(posedge clk) disable iff (rst)
        (coll_pulse && !$past(byte_upd)) |-> arb_lost);

    // R8
    byte_mode_commit_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(arb_lost) && $past(byte_upd)) |-> $past(byte_end));
endmodule

// File: rtl/sbam_start_trig.sv
module sbam_start_trig
    import sbam_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start_on_fall,
    input  logic tx_en,
    input  logic rxd_fall,
    output logic tx_start
);
    logic en_p;
    logic armed_q;
    logic start_q;
    logic en_rise;

    assign en_rise = rose(tx_en, en_p);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_p    <= 1'b0;
            armed_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            en_p <= tx_en;
            if (!tx_en) begin
                armed_q <= 1'b0;
            end else if (en_rise && start_on_fall) begin
                armed_q <= 1'b1;
            end else if (armed_q && rxd_fall) begin
                armed_q <= 1'b0;
            end
            if (start_on_fall) begin
                start_q <= armed_q & tx_en & rxd_fall;
            end else begin
                start_q <= en_rise;
            end
        end
    end

    assign tx_start = start_q;

    // R11
    start_single_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |=> !tx_start);

    // R12
    start_needs_en_chk: assert property (@(posedge clk) disable iff (rst)
        tx_start |-> $past(tx_en));
endmodule

// File: rtl/sbus_arb_monitor.sv
module sbus_arb_monitor
    import sbam_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic cfg_i2c_mode,
    input  logic cfg_smp_timer,
    input  logic cfg_byte_upd,
    input  logic cfg_auto_clr,
    input  logic cfg_start_on_fall,
    input  logic scl_in,
    input  logic sda_in,
    input  logic sda_drv,
    input  logic rxd_in,
    input  logic tmr_uflow,
    input  logic byte_end,
    input  logic tx_en,
    input  logic arb_clr,
    output logic bus_busy,
    output logic arb_lost,
    output logic coll_pulse,
    output logic tx_en_clr,
    output logic tx_start
);
    localparam logic [LINE_W-1:0] IDLE_LINES = '1;

    cfg_t  cfg;
    line_t line_raw;
    line_t line_s;
    line_t line_p;
    evt_t  evt;

    assign cfg = '{i2c_mode:      cfg_i2c_mode,
                   smp_src:       smp_src_e'(cfg_smp_timer),
                   byte_upd:      cfg_byte_upd,
                   auto_clr:      cfg_auto_clr,
                   start_on_fall: cfg_start_on_fall};

    assign line_raw = '{scl: scl_in, sda: sda_in, drv: sda_drv, rxd: rxd_in};

    sbam_sync #(
        .STAGES  (SYNC_STAGES),
        .WIDTH   (LINE_W),
        .RST_VAL (IDLE_LINES)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (line_raw),
        .q   (line_s)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            line_p <= IDLE_LINES;
        end else begin
            line_p <= line_s;
        end
    end

    always_comb begin
        evt.scl_rise   = rose(line_s.scl, line_p.scl);
        evt.start_cond = line_s.scl & line_p.scl & fell(line_s.sda, line_p.sda);
        evt.stop_cond  = line_s.scl & line_p.scl & rose(line_s.sda, line_p.sda);
        evt.rxd_fall   = fell(line_s.rxd, line_p.rxd);
    end

    sbam_cond_det u_cond (
        .clk      (clk),
        .rst      (rst),
        .i2c_mode (cfg.i2c_mode),
        .evt      (evt),
        .bus_busy (bus_busy)
    );

    sbam_coll u_coll (
        .clk        (clk),
        .rst        (rst),
        .smp_src    (cfg.smp_src),
        .byte_upd   (cfg.byte_upd),
        .auto_clr   (cfg.auto_clr),
        .scl_rise   (evt.scl_rise),
        .tmr_uflow  (tmr_uflow),
        .drv_lvl    (line_s.drv),
        .wire_lvl   (line_s.sda),
        .byte_end   (byte_end),
        .arb_clr    (arb_clr),
        .coll_pulse (coll_pulse),
        .tx_en_clr  (tx_en_clr),
        .arb_lost   (arb_lost)
    );

    sbam_start_trig u_trig (
        .clk           (clk),
        .rst           (rst),
        .start_on_fall (cfg.start_on_fall),
        .tx_en         (tx_en),
        .rxd_fall      (evt.rxd_fall),
        .tx_start      (tx_start)
    );

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> !(bus_busy | arb_lost | coll_pulse | tx_en_clr | tx_start));
endmodule

// File: tb/sbus_arb_monitor_bench.sv
`timescale 1ns/1ps
module sbus_arb_monitor_bench;
    localparam int S = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_i2c_mode = 0, cfg_smp_timer = 0, cfg_byte_upd = 0, cfg_auto_clr = 0, cfg_start_on_fall = 0;
    logic scl_in = 1, sda_in = 1, sda_drv = 1, rxd_in = 1;
    logic tmr_uflow = 0, byte_end = 0, tx_en = 0, arb_clr = 0;
    logic bus_busy, arb_lost, coll_pulse, tx_en_clr, tx_start;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    bit done = 0;

    typedef struct {
        int    kind;
        int    at;
        string req;
    } exp_t;
    exp_t q[$];

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    sbus_arb_monitor #(.SYNC_STAGES(S)) u_sbus_arb_monitor (
        .clk(clk), .rst(rst),
        .cfg_i2c_mode(cfg_i2c_mode), .cfg_smp_timer(cfg_smp_timer),
        .cfg_byte_upd(cfg_byte_upd), .cfg_auto_clr(cfg_auto_clr),
        .cfg_start_on_fall(cfg_start_on_fall),
        .scl_in(scl_in), .sda_in(sda_in), .sda_drv(sda_drv), .rxd_in(rxd_in),
        .tmr_uflow(tmr_uflow), .byte_end(byte_end), .tx_en(tx_en), .arb_clr(arb_clr),
        .bus_busy(bus_busy), .arb_lost(arb_lost), .coll_pulse(coll_pulse),
        .tx_en_clr(tx_en_clr), .tx_start(tx_start)
    );

    task automatic check(input string req, input logic act, input logic exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // kind: 0 coll_pulse, 1 tx_en_clr, 2 tx_start
    task automatic expect_pulse(input int kind, input int at, input string req);
        exp_t e;
        e.kind = kind; e.at = at; e.req = req;
        q.push_back(e);
    endtask

    task automatic take(input int kind, input string who);
        exp_t e;
        nchk++;
        if (q.size() == 0) begin
            nfail++;
            $display("FAIL %s unexpected pulse at cycle %0d: actual 1 expected 0", who, cyc);
        end else begin
            e = q.pop_front();
            if (e.kind != kind || e.at != cyc) begin
                nfail++;
                $display("FAIL %s: actual kind %0d at cycle %0d expected kind %0d at cycle %0d",
                         e.req, kind, cyc, e.kind, e.at);
            end
        end
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (coll_pulse) take(0, "R4 coll_pulse");
            if (tx_en_clr)  take(1, "R10 tx_en_clr");
            if (tx_start)   take(2, "R12 tx_start");
        end
    end

    task automatic timer_pulse();
        tmr_uflow = 1; tick(1); tmr_uflow = 0;
    endtask

    task automatic clear_arb();
        arb_clr = 1; tick(1); arb_clr = 0; tick(1);
    endtask

    task automatic finish_run();
        done = 1;
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        #(4 * 100000);
        nchk++; nfail++;
        $display("FAIL watchdog expired at cycle %0d: actual running expected done", cyc);
        finish_run();
    end

    initial begin
        tick(3);
        // R1
        check("R1 busy in reset", bus_busy, 0);
        check("R1 arb in reset", arb_lost, 0);
        check("R1 start in reset", tx_start, 0);
        rst = 0;
        tick(S + 3);
        check("R1 busy after reset", bus_busy, 0);
        check("R1 arb after reset", arb_lost, 0);

        // R3: ordinary mode ignores START
        sda_in = 0; tick(S + 4);
        check("R3 busy ignored", bus_busy, 0);
        sda_in = 1; tick(S + 4);

        // R2: START then STOP in bus mode
        cfg_i2c_mode = 1; tick(2);
        sda_in = 0; tick(S);
        check("R2 busy before latency", bus_busy, 0);
        tick(1);
        check("R2 busy set by START", bus_busy, 1);
        sda_in = 1; tick(S + 1);
        check("R2 busy cleared by STOP", bus_busy, 0);
        cfg_i2c_mode = 0; tick(2);

        // R5/R4/R7: clock-rise sampling with collision, per-bit flag
        scl_in = 0; tick(S + 2);
        sda_in = 0; sda_drv = 1; tick(S + 2);
        expect_pulse(0, cyc + 1 + S, "R5 coll on clock rise");
        scl_in = 1; tick(S);
        check("R7 arb before pulse", arb_lost, 0);
        tick(1);
        check("R7 arb with pulse", arb_lost, 1);
        tick(4);
        check("R9 arb sticky", arb_lost, 1);
        clear_arb();
        check("R9 arb cleared", arb_lost, 0);

        // R4: driven low does not collide
        scl_in = 0; sda_drv = 0; tick(S + 2);
        scl_in = 1; tick(S + 3);
        check("R4 no coll when driving low", arb_lost, 0);
        // R4: wire matches released level
        scl_in = 0; sda_drv = 1; sda_in = 1; tick(S + 2);
        scl_in = 1; tick(S + 3);
        check("R4 no coll when levels match", arb_lost, 0);

        // R5: timer ignored in clock-rise mode
        sda_in = 0; tick(S + 2);
        timer_pulse(); tick(3);
        check("R5 timer ignored", arb_lost, 0);

        // R6: timer sampling, clock rise ignored
        cfg_smp_timer = 1; scl_in = 0; tick(S + 2);
        scl_in = 1; tick(S + 3);
        check("R6 clock rise ignored", arb_lost, 0);
        expect_pulse(0, cyc + 1, "R6 coll on timer");
        timer_pulse(); tick(2);
        check("R6 arb from timer", arb_lost, 1);
        clear_arb();

        // R10: auto clear
        cfg_auto_clr = 1; tick(1);
        expect_pulse(0, cyc + 1, "R10 coll");
        expect_pulse(1, cyc + 1, "R10 clr with coll");
        timer_pulse(); tick(2);
        cfg_auto_clr = 0;
        clear_arb();

        // R9: collision beats clear in same cycle
        expect_pulse(0, cyc + 1, "R9 coll");
        tmr_uflow = 1; arb_clr = 1; tick(1);
        tmr_uflow = 0; arb_clr = 0; tick(1);
        check("R9 set wins over clear", arb_lost, 1);
        clear_arb();

        // R8: per-byte commit
        cfg_byte_upd = 1; tick(1);
        expect_pulse(0, cyc + 1, "R8 coll");
        timer_pulse(); tick(4);
        check("R8 arb held until byte end", arb_lost, 0);
        byte_end = 1; tick(1); byte_end = 0;
        check("R8 arb at byte end", arb_lost, 1);
        clear_arb();
        byte_end = 1; tick(1); byte_end = 0; tick(1);
        check("R8 empty byte end", arb_lost, 0);
        cfg_byte_upd = 0; cfg_smp_timer = 0; tick(2);

        // R11: immediate start
        expect_pulse(2, cyc + 1, "R11 start on enable");
        tx_en = 1; tick(3);
        tx_en = 0; tick(3);

        // R12: start on receive fall
        cfg_start_on_fall = 1; tick(1);
        tx_en = 1; tick(S + 4);
        expect_pulse(2, cyc + 1 + S, "R12 start on rxd fall");
        rxd_in = 0; tick(S + 4);
        rxd_in = 1; tick(S + 2);
        rxd_in = 0; tick(S + 4);
        check("R12 second fall ignored", tx_start, 0);
        tx_en = 0; rxd_in = 1; tick(4);

        nchk++;
        if (q.size() != 0) begin
            nfail++;
            $display("FAIL %s: actual %0d pending pulses expected 0", q[0].req, q.size());
        end
        finish_run();
    end
endmodule